// File: doc/BRIEF.md
# Double-Banked IN Endpoint Transmit Buffer

This block buffers outgoing payloads for a single USB device IN endpoint using two storage banks. Firmware loads bytes into one bank while the serial engine streams the other bank onto the bus. The two sides coordinate through per-bank flags. Firmware raises a "payload ready" flag once a bank is filled. Hardware drops that flag when it takes the bank for sending. Firmware alone clears the "transmit done" flag, which the host's ACK sets.

On the bus side, an IN-token request is answered one cycle later with either a DATA or a NAK reply strobe. After a DATA reply, the engine pulls bytes through a read strobe until the latched length is used up. It then reports ACK or abort. An ACK frees the bank and moves transmission to the other bank. An abort (timeout or error) puts the same payload back in the ready state so that it is sent again. Packet framing, PIDs, CRC and the data toggle are handled outside this block.

Top module: `usb_pp_in_ep`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) empties both banks, clears the ready, done and overrun flags, and selects bank 0 for both the firmware pointer and the bus pointer.
- R2: If an IN token arrives while the bus bank is not ready, `reply_nak_o` pulses on the next cycle and `reply_data_o` stays low. The two reply strobes are never high together.
- R3: An accepted `fw_ready_set` sets `ready_o[b]` for the firmware bank `b` (bit index equals bank number) and toggles `fw_bank_o` to the other bank.
- R4: An IN token with the bus bank ready gives a `reply_data_o` pulse on the next cycle and clears that bank's ready flag. The bank's bytes are then delivered in address order, one per `rd_en` while `rd_valid_o` is high, and `rd_last_o` marks the final byte.
- R5: Firmware may write and mark the other bank while a packet is being read out, and that payload is sent intact afterwards.
- R6: A host ACK during a transfer sets `irq_o`. It stays set until a `fw_done_clr` strobe, and a simultaneous ACK takes priority over the clear.
- R7: `abort_in` during a transfer (with no ACK) restores the bank's ready flag and keeps the bus bank unchanged, so the next IN token resends the same bytes.
- R8: Successive acknowledged packets are taken from bank 0, then bank 1, then bank 0, and so on.
- R9: A ready length of zero produces a DATA reply with `rd_valid_o` never asserted (a zero-length packet).
- R10: `fw_ready_set` is ignored while the firmware bank is not empty (both banks hold payloads). In that case it sets the sticky `overrun_o`, leaves the ready flags unchanged, and byte writes to that bank are ignored.
- R11: A ready length larger than the bank size is clamped to the bank size when latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fw_wr_en | input | 1 | Firmware byte write into the firmware bank |
| fw_wr_addr | input | ADDR_W | Byte address within the bank |
| fw_wr_data | input | DATA_W | Byte to write |
| fw_ready_set | input | 1 | Mark the firmware bank ready |
| fw_ready_len | input | CNT_W | Payload length latched with the ready strobe |
| fw_done_clr | input | 1 | Clear the transmit-done flag |
| fw_bank_o | output | 1 | Bank currently targeted by firmware writes |
| ready_o | output | 2 | Per-bank ready flags |
| irq_o | output | 1 | Transmit-done pending interrupt |
| overrun_o | output | 1 | Sticky flag for rejected ready strobes |
| in_token | input | 1 | IN token request from the bus engine |
| reply_data_o | output | 1 | Reply strobe: send DATA |
| reply_nak_o | output | 1 | Reply strobe: send NAK |
| rd_en | input | 1 | Consume the current byte |
| rd_valid_o | output | 1 | A byte is available |
| rd_data_o | output | DATA_W | Current byte |
| rd_last_o | output | 1 | Current byte is the final one |
| ack_in | input | 1 | Host acknowledged the packet |
| abort_in | input | 1 | Transfer failed without ACK |
| usb_bank_o | output | 1 | Bank the bus side sends next or is sending |

## Verification
Directed sequences cover the corner cases. An empty token tells NAK apart from DATA. Two full banks followed by an extra ready strobe separate acceptance from overrun. A zero-length and an oversized length exercise the length latch. An abort followed by a resend shows that requeueing differs from release. Constrained-random payloads of 0 to 64 bytes then run through single and back-to-back loads, with random aborts. Each packet's bytes and count are compared with a bench model of both bank pointers, which shows that the alternation and the concurrent filling never mix data between banks.

// File: rtl/usb_pp_in_pkg.sv
package usb_pp_in_pkg;

  typedef enum logic [1:0] {
    BK_EMPTY = 2'd0,
    BK_READY = 2'd1,
    BK_BUSY  = 2'd2
  } bank_state_e;

  // Limit a requested payload length to the bank capacity.
  function automatic int unsigned clamp_len(input int unsigned req, input int unsigned cap);
    return (req > cap) ? cap : req;
  endfunction

  // The only other bank of the pair.
  function automatic logic other_bank(input logic b);
    return ~b;
  endfunction

endpackage

// File: rtl/ppin_bank_state.sv
module ppin_bank_state
  import usb_pp_in_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        set_i,
  input  logic        take_i,
  input  logic        ack_i,
  input  logic        abort_i,
  output bank_state_e state_o
);

  bank_state_e st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= BK_EMPTY;
    end else begin
      unique case (st_q)
        BK_EMPTY: if (set_i)   st_q <= BK_READY;
        BK_READY: if (take_i)  st_q <= BK_BUSY;
        BK_BUSY: begin
          if (ack_i)           st_q <= BK_EMPTY;
          else if (abort_i)    st_q <= BK_READY;
        end
        default:               st_q <= BK_EMPTY;
      endcase
    end
  end

  assign state_o = st_q;

endmodule

// File: rtl/ppin_bank_store.sv
module ppin_bank_store #(
  parameter int BANK_BYTES = 64,
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 6,
  parameter int CNT_W      = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_bank,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              len_load,
  input  logic              len_bank,
  input  logic [CNT_W-1:0]  len_val,
  input  logic              rd_bank,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  rd_len
);

  localparam int NBANK = 2;

  logic [DATA_W-1:0] mem_q [NBANK][BANK_BYTES];
  logic [NBANK-1:0][CNT_W-1:0] len_all;

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_bank][wr_addr] <= wr_data;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_len
    logic [CNT_W-1:0] len_r;
    always_ff @(posedge clk) begin
      if (rst)                                 len_r <= '0;
      else if (len_load && (len_bank == b[0])) len_r <= len_val;
    end
    assign len_all[b] = len_r;
  end

  assign rd_data = mem_q[rd_bank][rd_addr];
  assign rd_len  = len_all[rd_bank];

endmodule

// File: rtl/ppin_usb_engine.sv
module ppin_usb_engine
  import usb_pp_in_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_token,
  input  logic              ack_in,
  input  logic              abort_in,
  input  logic              rd_en,
  input  logic              cur_ready,
  input  logic [CNT_W-1:0]  cur_len,
  output logic              take_o,
  output logic              nak_o,
  output logic              ack_evt_o,
  output logic              abort_evt_o,
  output logic              sending_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              rd_valid_o,
  output logic              rd_last_o,
  output logic              reply_data_o,
  output logic              reply_nak_o,
  output logic              bank_o
);

  logic             sending_q;
  logic [CNT_W-1:0] ptr_q;
  logic             bank_q;
  logic             rdata_q, rnak_q;
  logic             pop;

  assign take_o      = in_token && !sending_q && cur_ready;
  assign nak_o       = in_token && !sending_q && !cur_ready;
  assign ack_evt_o   = sending_q && ack_in;
  assign abort_evt_o = sending_q && abort_in && !ack_in;
  assign rd_valid_o  = sending_q && (ptr_q < cur_len);
  assign rd_last_o   = rd_valid_o && (ptr_q == cur_len - 1'b1);
  assign pop         = rd_en && rd_valid_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      sending_q <= 1'b0;
      ptr_q     <= '0;
      bank_q    <= 1'b0;
      rdata_q   <= 1'b0;
      rnak_q    <= 1'b0;
    end else begin
      rdata_q <= take_o;
      rnak_q  <= nak_o;
      if (take_o) begin
        sending_q <= 1'b1;
        ptr_q     <= '0;
      end else if (ack_evt_o) begin
        sending_q <= 1'b0;
        bank_q    <= other_bank(bank_q);
      end else if (abort_evt_o) begin
        sending_q <= 1'b0;
      end else if (pop) begin
        ptr_q <= ptr_q + 1'b1;
      end
    end
  end

  assign sending_o    = sending_q;
  assign rd_addr_o    = ptr_q[ADDR_W-1:0];
  assign reply_data_o = rdata_q;
  assign reply_nak_o  = rnak_q;
  assign bank_o       = bank_q;

endmodule

// File: rtl/usb_pp_in_ep.sv
module usb_pp_in_ep
  import usb_pp_in_pkg::*;
#(
  parameter int BANK_BYTES = 64,
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = $clog2(BANK_BYTES),
  parameter int CNT_W      = $clog2(BANK_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fw_wr_en,
  input  logic [ADDR_W-1:0] fw_wr_addr,
  input  logic [DATA_W-1:0] fw_wr_data,
  input  logic              fw_ready_set,
  input  logic [CNT_W-1:0]  fw_ready_len,
  input  logic              fw_done_clr,
  output logic              fw_bank_o,
  output logic [1:0]        ready_o,
  output logic              irq_o,
  output logic              overrun_o,
  input  logic              in_token,
  output logic              reply_data_o,
  output logic              reply_nak_o,
  input  logic              rd_en,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_last_o,
  input  logic              ack_in,
  input  logic              abort_in,
  output logic              usb_bank_o
);

  localparam int NBANK = 2;

  // Named internal events
  logic             fw_bank_q, done_q, ovr_q;
  logic             fw_free, fw_accept, fw_reject, fw_write;
  logic             usb_take, usb_nak, usb_ack_evt, usb_abort_evt, usb_sending;
  logic             usb_bank;
  logic [NBANK-1:0] ready_vec, empty_vec;
  logic [ADDR_W-1:0] rd_addr;
  logic [CNT_W-1:0]  cur_len, len_latched;

  assign fw_free     = empty_vec[fw_bank_q];
  assign fw_accept   = fw_ready_set && fw_free;
  assign fw_reject   = fw_ready_set && !fw_free;
  assign fw_write    = fw_wr_en && fw_free;
  assign len_latched = CNT_W'(clamp_len(32'(fw_ready_len), BANK_BYTES));

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    bank_state_e st;
    ppin_bank_state u_state (
      .clk     (clk),
      .rst     (rst),
      .set_i   (fw_accept && (fw_bank_q == b[0])),
      .take_i  (usb_take && (usb_bank == b[0])),
      .ack_i   (usb_ack_evt && (usb_bank == b[0])),
      .abort_i (usb_abort_evt && (usb_bank == b[0])),
      .state_o (st)
    );
    assign ready_vec[b] = (st == BK_READY);
    assign empty_vec[b] = (st == BK_EMPTY);
  end

  ppin_bank_store #(
    .BANK_BYTES (BANK_BYTES),
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .CNT_W      (CNT_W)
  ) u_store (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (fw_write),
    .wr_bank  (fw_bank_q),
    .wr_addr  (fw_wr_addr),
    .wr_data  (fw_wr_data),
    .len_load (fw_accept),
    .len_bank (fw_bank_q),
    .len_val  (len_latched),
    .rd_bank  (usb_bank),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data_o),
    .rd_len   (cur_len)
  );

  ppin_usb_engine #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) u_eng (
    .clk          (clk),
    .rst          (rst),
    .in_token     (in_token),
    .ack_in       (ack_in),
    .abort_in     (abort_in),
    .rd_en        (rd_en),
    .cur_ready    (ready_vec[usb_bank]),
    .cur_len      (cur_len),
    .take_o       (usb_take),
    .nak_o        (usb_nak),
    .ack_evt_o    (usb_ack_evt),
    .abort_evt_o  (usb_abort_evt),
    .sending_o    (usb_sending),
    .rd_addr_o    (rd_addr),
    .rd_valid_o   (rd_valid_o),
    .rd_last_o    (rd_last_o),
    .reply_data_o (reply_data_o),
    .reply_nak_o  (reply_nak_o),
    .bank_o       (usb_bank)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fw_bank_q <= 1'b0;
      done_q    <= 1'b0;
      ovr_q     <= 1'b0;
    end else begin
      if (fw_accept)        fw_bank_q <= other_bank(fw_bank_q);
      if (fw_reject)        ovr_q     <= 1'b1;
      if (usb_ack_evt)      done_q    <= 1'b1;
      else if (fw_done_clr) done_q    <= 1'b0;
    end
  end

  assign fw_bank_o  = fw_bank_q;
  assign ready_o    = ready_vec;
  assign irq_o      = done_q;
  assign overrun_o  = ovr_q;
  assign usb_bank_o = usb_bank;

endmodule

// File: rtl/usb_pp_in_ep_chk.sv
module usb_pp_in_ep_chk (
  input logic       clk,
  input logic       rst,
  input logic       reply_data_o,
  input logic       reply_nak_o,
  input logic [1:0] ready_o,
  input logic       irq_o,
  input logic       overrun_o,
  input logic       fw_done_clr,
  input logic       fw_bank_o,
  input logic       usb_bank_o,
  input logic       rd_valid_o,
  input logic       usb_take,
  input logic       usb_nak,
  input logic       usb_sending,
  input logic       usb_ack_evt,
  input logic       usb_abort_evt,
  input logic       fw_accept,
  input logic       fw_reject
);

  assert_reply_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    !(reply_data_o && reply_nak_o));

  assert_nak_reply_R2: assert property (@(posedge clk) disable iff (rst)
    usb_nak |=> reply_nak_o && !reply_data_o);

  assert_fw_bank_moves_R3: assert property (@(posedge clk) disable iff (rst)
    fw_accept |=> fw_bank_o != $past(fw_bank_o));

  assert_take_clears_ready_R4: assert property (@(posedge clk) disable iff (rst)
    usb_take |=> !ready_o[$past(usb_bank_o)] && reply_data_o);

  assert_valid_only_sending_R4: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o |-> usb_sending);

  assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !fw_done_clr) |=> irq_o);

  assert_ack_sets_irq_R6: assert property (@(posedge clk) disable iff (rst)
    usb_ack_evt |=> irq_o);

  assert_abort_requeue_R7: assert property (@(posedge clk) disable iff (rst)
    usb_abort_evt |=> ready_o[$past(usb_bank_o)] && (usb_bank_o == $past(usb_bank_o)));

  assert_ack_alternates_R8: assert property (@(posedge clk) disable iff (rst)
    usb_ack_evt |=> usb_bank_o != $past(usb_bank_o));

  assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    overrun_o |=> overrun_o);

  assert_reject_keeps_ready_R10: assert property (@(posedge clk) disable iff (rst)
    (fw_reject && !usb_take && !usb_ack_evt && !usb_abort_evt) |=>
      (ready_o == $past(ready_o)) && overrun_o);

endmodule

bind usb_pp_in_ep usb_pp_in_ep_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .reply_data_o  (reply_data_o),
  .reply_nak_o   (reply_nak_o),
  .ready_o       (ready_o),
  .irq_o         (irq_o),
  .overrun_o     (overrun_o),
  .fw_done_clr   (fw_done_clr),
  .fw_bank_o     (fw_bank_o),
  .usb_bank_o    (usb_bank_o),
  .rd_valid_o    (rd_valid_o),
  .usb_take      (usb_take),
  .usb_nak       (usb_nak),
  .usb_sending   (usb_sending),
  .usb_ack_evt   (usb_ack_evt),
  .usb_abort_evt (usb_abort_evt),
  .fw_accept     (fw_accept),
  .fw_reject     (fw_reject)
);

// File: tb/usb_pp_in_ep_tb.sv
`timescale 1ns/1ps
module usb_pp_in_ep_tb;

  localparam int BANK_BYTES = 64;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 6;
  localparam int CNT_W      = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fw_wr_en = 0, fw_ready_set = 0, fw_done_clr = 0;
  logic [ADDR_W-1:0] fw_wr_addr = '0;
  logic [DATA_W-1:0] fw_wr_data = '0;
  logic [CNT_W-1:0]  fw_ready_len = '0;
  logic in_token = 0, rd_en = 0, ack_in = 0, abort_in = 0;
  logic fw_bank_o, irq_o, overrun_o, reply_data_o, reply_nak_o;
  logic rd_valid_o, rd_last_o, usb_bank_o;
  logic [1:0] ready_o;
  logic [DATA_W-1:0] rd_data_o;

  always #2 clk = ~clk;

  usb_pp_in_ep #(.BANK_BYTES(BANK_BYTES), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst(rst), .fw_wr_en(fw_wr_en), .fw_wr_addr(fw_wr_addr),
    .fw_wr_data(fw_wr_data), .fw_ready_set(fw_ready_set), .fw_ready_len(fw_ready_len),
    .fw_done_clr(fw_done_clr), .fw_bank_o(fw_bank_o), .ready_o(ready_o), .irq_o(irq_o),
    .overrun_o(overrun_o), .in_token(in_token), .reply_data_o(reply_data_o),
    .reply_nak_o(reply_nak_o), .rd_en(rd_en), .rd_valid_o(rd_valid_o),
    .rd_data_o(rd_data_o), .rd_last_o(rd_last_o), .ack_in(ack_in),
    .abort_in(abort_in), .usb_bank_o(usb_bank_o));

  int nchk = 0, nfail = 0;
  logic [7:0] exp_mem [2][BANK_BYTES];
  int exp_len [2];
  int m_fw = 0, m_usb = 0;

  function automatic int exp_clamp(input int n);
    if (n > BANK_BYTES) return BANK_BYTES;
    return n;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Fill the firmware bank with random bytes, then mark it ready with len.
  task automatic load_and_set(input int nbytes, input int len);
    for (int i = 0; i < nbytes; i++) begin
      @(negedge clk);
      fw_wr_en = 1; fw_wr_addr = ADDR_W'(i); fw_wr_data = 8'($urandom);
      exp_mem[m_fw][i] = fw_wr_data;
    end
    @(negedge clk);
    fw_wr_en = 0;
    fw_ready_set = 1; fw_ready_len = CNT_W'(len);
    exp_len[m_fw] = exp_clamp(len);
    @(negedge clk);
    fw_ready_set = 0;
    m_fw = 1 - m_fw;
  endtask

  // Token, read out and finish with ACK (1) or abort (0).
  task automatic send(input bit do_ack, input string req);
    int n;
    bit bytes_ok;
    bit last_ok;
    @(negedge clk);
    in_token = 1;
    @(negedge clk);
    in_token = 0;
    chk(reply_data_o && !reply_nak_o, req, reply_data_o, 1);
    chk(ready_o[m_usb] == 1'b0, {req, " ready cleared R4"}, ready_o[m_usb], 0);
    chk(usb_bank_o == m_usb[0], {req, " bank R8"}, usb_bank_o, m_usb);
    n = 0; bytes_ok = 1; last_ok = 1;
    while (rd_valid_o && n < BANK_BYTES + 8) begin
      if (rd_data_o != exp_mem[m_usb][n]) bytes_ok = 0;
      if (rd_last_o != (n == exp_len[m_usb] - 1)) last_ok = 0;
      rd_en = 1;
      @(negedge clk);
      n++;
    end
    rd_en = 0;
    chk(n == exp_len[m_usb], {req, " count R4"}, n, exp_len[m_usb]);
    chk(bytes_ok && last_ok, {req, " bytes R4"}, bytes_ok, 1);
    if (do_ack) ack_in = 1; else abort_in = 1;
    @(negedge clk);
    ack_in = 0; abort_in = 0;
    if (do_ack) begin
      chk(irq_o == 1'b1, {req, " irq R6"}, irq_o, 1);
      m_usb = 1 - m_usb;
    end else begin
      chk(ready_o[m_usb] == 1'b1 && usb_bank_o == m_usb[0], {req, " requeue R7"},
          ready_o[m_usb], 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(ready_o == 2'b00 && !irq_o && !overrun_o && !fw_bank_o && !usb_bank_o && !rd_valid_o,
        "R1 reset", {ready_o, irq_o, overrun_o}, 0);

    // R2 token with nothing ready
    in_token = 1;
    @(negedge clk);
    in_token = 0;
    chk(reply_nak_o && !reply_data_o, "R2 nak", reply_nak_o, 1);

    // R3 set marks bank 0 and moves fw pointer
    load_and_set(10, 10);
    chk(ready_o == 2'b01 && fw_bank_o == 1'b1, "R3 set", {ready_o, fw_bank_o}, 3'b011);

    // R5 load bank 1 during readout of bank 0
    fork
      send(1, "R4 first");
      load_and_set(20, 20);
    join
    chk(ready_o[1] == 1'b1, "R5 concurrent ready", ready_o[1], 1);
    send(1, "R5 R8 second");

    // R6 clear, then sticky
    @(negedge clk);
    chk(irq_o == 1'b1, "R6 sticky", irq_o, 1);
    fw_done_clr = 1;
    @(negedge clk);
    fw_done_clr = 0;
    chk(irq_o == 1'b0, "R6 clear", irq_o, 0);

    // R7 abort then resend same data
    load_and_set(7, 7);
    send(0, "R7 abort");
    send(1, "R7 resend");

    // R9 zero-length packet
    load_and_set(0, 0);
    send(1, "R9 zlp");

    // R10 overrun: fill both, then extra set and write are ignored
    load_and_set(5, 5);
    load_and_set(6, 6);
    chk(ready_o == 2'b11 && !overrun_o, "R10 both full", ready_o, 3);
    @(negedge clk);
    fw_wr_en = 1; fw_wr_addr = '0; fw_wr_data = ~exp_mem[m_fw][0];
    @(negedge clk);
    fw_wr_en = 0; fw_ready_set = 1; fw_ready_len = 7'd3;
    @(negedge clk);
    fw_ready_set = 0;
    chk(overrun_o && ready_o == 2'b11 && fw_bank_o == m_fw[0], "R10 ignored",
        {overrun_o, ready_o}, 7);
    send(1, "R10 data intact");
    send(1, "R10 data intact b");
    chk(overrun_o == 1'b1, "R10 sticky", overrun_o, 1);

    // R11 clamp
    load_and_set(64, 100);
    send(1, "R11 clamp");

    // Random mix
    for (int it = 0; it < 40; it++) begin
      int l1, l2;
      l1 = $urandom_range(0, BANK_BYTES);
      load_and_set(l1, l1);
      if ((it % 3) == 0) begin
        l2 = $urandom_range(0, BANK_BYTES);
        load_and_set(l2, l2);
        send(1, "R8 rand pair a");
        send(($urandom_range(0, 3) != 0), "R7 rand pair b");
        if (ready_o != 2'b00) send(1, "R7 rand retry");
      end else begin
        if ($urandom_range(0, 3) == 0) send(0, "R7 rand abort");
        send(1, "R4 rand");
      end
    end

    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule